// File: doc/BRIEF.md
# Command-Response Buffer Control Register Block

This block holds the control and status registers that software uses to hand commands to a security coprocessor through a shared command/response buffer. Software reaches it over a simple byte-addressable register bus. Each access is 1 to 4 bytes wide and little-endian. The block tracks whether a locality has been granted, and whether the engine is idle or ready for a command. It runs the start and cancel handshakes with a backend engine and records the completion status that the backend reports.

The address space is split into 4 KiB locality windows. Address bits [15:12] give the locality of an access. Bits [11:0] select the register inside the window, and reads mirror the same registers in every window. Action registers decode their side effects from the exact value written. Individual bits have no meaning on their own. A command start is accepted only through the window of the assigned locality. Only locality 0 can ever be active, so that window is the one that counts.

Top module: `crb_ctrl_regs`

## Requirements
- R1: After reset the registers read as follows:
  - locality state (offset 0x000) reads 0x80, with bit 7 = registers valid and bit 0 clear while the established input is high;
  - locality status (0x00C) reads 0;
  - control status (0x044) reads 0x2, with bit 1 = idle and bit 0 = fatal error;
  - start (0x04C) reads 0;
  - interface ID (0x030) reads 0x00025811, made up of type 1 in [3:0], version 1 in [7:4], transfer-size code 3 in [12:11], buffer interface supported at bit 14 and selector 1 in [18:17];
  - interface ID 2 (0x034) reads the vendor ID parameter;
  - command size (0x058) and response size (0x064) read the buffer size, which is the window size minus the buffer offset (0xF80);
  - command address (0x05C) and response address (0x068) read the base address plus the buffer offset (0xFED40080).
- R2: Reads of the locality-state register return the inverse of the `est_flag` input in bit 0.
- R3: A read returns the 32-bit word that contains the address, shifted right by 8 times address bits [1:0].
- R4: In the control-request register (0x040), a written value of exactly 0x1 clears the idle bit and exactly 0x2 sets it. Any other value leaves the idle bit unchanged.
- R5: In the locality-control register (0x008), exactly 0x1 sets locality-assigned (locality state bit 1) and granted (locality status bit 0), and clears been-seized (locality status bit 1). Exactly 0x2 clears both assigned and granted. The value 0x8 and every other value have no effect. The active-locality field (locality state bits [4:2]) always reads 0.
- R6: Writing exactly 0x1 to the start register while the start bit is clear and locality 0 is assigned, through the locality-0 window, sets start bit 0 and raises `start_req` for exactly one cycle.
- R7: A start write is rejected, with no pulse and no change, in each of these cases: no locality is assigned, the write comes through another locality window, the value is not 0x1, or the start bit is already set.
- R8: Writing exactly 0x1 to the cancel register (0x048) raises `cancel_pulse` for one cycle only while the start bit is set. Otherwise the write has no effect.
- R9: A `done_strb` while the start bit is set clears the start bit. If `done_err` is high as well, it also sets the fatal-error bit, which stays set until reset. A `done_strb` while the start bit is clear is ignored.
- R10: For writes narrower than 4 bytes, the action registers compare a word built from the written byte lanes only, with every unwritten lane taken as zero. A byte of 0x01 written at offset 1 of the start register is therefore ignored, and data bits outside the access size are discarded.
- R11: Writes to read-only or unmapped offsets change no readable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte address; [15:12] locality, [11:0] register offset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_size | input | 2 | Access size in bytes minus one |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| est_flag | input | 1 | Backend established flag |
| done_strb | input | 1 | Backend completion strobe |
| done_err | input | 1 | Completion carries an error |
| start_req | output | 1 | One-cycle start request to backend |
| cancel_pulse | output | 1 | One-cycle cancel request to backend |

## Verification
The hardest state to reach is a command in flight that gets a cancel, a stray completion or a second start while the start bit is already set. The stimulus first claims the locality, then issues an accepted start, and only then sends the competing writes and strobes. Start writes that nearly qualify are sent before that point: one through the window of another locality, one with no locality assigned, and narrow writes whose single byte lands on the wrong lane. These show that the acceptance rule uses every one of its conditions.

// File: rtl/crb_ctrl_regs.sv
module crb_ctrl_regs #(
  parameter int          ADDR_W    = 16,
  parameter int          LOC_LSB   = 12,
  parameter logic [31:0] BASE_ADDR = 32'hFED4_0000,
  parameter logic [31:0] WIN_BYTES = 32'h0000_1000,
  parameter logic [31:0] DBUF_OFF  = 32'h0000_0080,
  parameter logic [15:0] VENDOR_ID = 16'h1014
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              est_flag,
  input  logic              done_strb,
  input  logic              done_err,
  output logic              start_req,
  output logic              cancel_pulse
);
  localparam int IW = LOC_LSB - 2;
  localparam logic [IW-1:0] W_LSTATE = IW'(12'h000 >> 2);
  localparam logic [IW-1:0] W_LCTRL  = IW'(12'h008 >> 2);
  localparam logic [IW-1:0] W_LSTS   = IW'(12'h00C >> 2);
  localparam logic [IW-1:0] W_IFID   = IW'(12'h030 >> 2);
  localparam logic [IW-1:0] W_IFID2  = IW'(12'h034 >> 2);
  localparam logic [IW-1:0] W_REQ    = IW'(12'h040 >> 2);
  localparam logic [IW-1:0] W_STS    = IW'(12'h044 >> 2);
  localparam logic [IW-1:0] W_CANCEL = IW'(12'h048 >> 2);
  localparam logic [IW-1:0] W_START  = IW'(12'h04C >> 2);
  localparam logic [IW-1:0] W_CSIZE  = IW'(12'h058 >> 2);
  localparam logic [IW-1:0] W_CADDR  = IW'(12'h05C >> 2);
  localparam logic [IW-1:0] W_RSIZE  = IW'(12'h064 >> 2);
  localparam logic [IW-1:0] W_RADDR  = IW'(12'h068 >> 2);
  localparam logic [31:0] BUF_SIZE = WIN_BYTES - DBUF_OFF;
  localparam logic [31:0] BUF_ADDR = BASE_ADDR + DBUF_OFF;
  localparam logic [31:0] IFID_VAL = 32'h0000_0001 | 32'h0000_0010 | (32'd3 << 11)
                                   | (32'd1 << 14) | (32'd1 << 17);

  logic loc_assigned, granted, idle, fatal, start_bit;

  wire [IW-1:0] word_idx = bus_addr[LOC_LSB-1:2];
  wire [7:0]    wr_loc   = 8'(bus_addr[ADDR_W-1:LOC_LSB]);
  wire [7:0]    act_loc  = loc_assigned ? 8'h00 : 8'hFF;

  logic [31:0] lane_mask;
  always_comb begin
    case (bus_size)
      2'd0:    lane_mask = 32'h0000_00FF;
      2'd1:    lane_mask = 32'h0000_FFFF;
      2'd2:    lane_mask = 32'h00FF_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  end
  wire [31:0] wword = (bus_wdata & lane_mask) << {bus_addr[1:0], 3'b000};

  wire hit_req    = bus_wr && word_idx == W_REQ;
  wire hit_lctrl  = bus_wr && word_idx == W_LCTRL;
  wire hit_cancel = bus_wr && word_idx == W_CANCEL;
  wire hit_start  = bus_wr && word_idx == W_START;

  wire start_ok  = hit_start && wword == 32'd1 && !start_bit && act_loc == wr_loc;
  wire cancel_ok = hit_cancel && wword == 32'd1 && start_bit;
  wire finish    = done_strb && start_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_assigned <= 1'b0;
      granted      <= 1'b0;
      idle         <= 1'b1;
      fatal        <= 1'b0;
      start_bit    <= 1'b0;
      start_req    <= 1'b0;
      cancel_pulse <= 1'b0;
    end else begin
      start_req    <= start_ok;
      cancel_pulse <= cancel_ok;
      if (hit_req && wword == 32'd1) idle <= 1'b0;
      if (hit_req && wword == 32'd2) idle <= 1'b1;
      if (hit_lctrl && wword == 32'd1) begin
        loc_assigned <= 1'b1;
        granted      <= 1'b1;
      end
      if (hit_lctrl && wword == 32'd2) begin
        loc_assigned <= 1'b0;
        granted      <= 1'b0;
      end
      if (start_ok) start_bit <= 1'b1;
      if (finish) begin
        start_bit <= 1'b0;
        if (done_err) fatal <= 1'b1;
      end
    end
  end

  logic [31:0] word_val;
  always_comb begin
    case (word_idx)
      W_LSTATE: word_val = {24'd0, 1'b1, 4'd0, 1'b0, loc_assigned, !est_flag};
      W_LSTS:   word_val = {30'd0, 1'b0, granted};
      W_IFID:   word_val = IFID_VAL;
      W_IFID2:  word_val = {16'd0, VENDOR_ID};
      W_STS:    word_val = {30'd0, idle, fatal};
      W_START:  word_val = {31'd0, start_bit};
      W_CSIZE:  word_val = BUF_SIZE;
      W_CADDR:  word_val = BUF_ADDR;
      W_RSIZE:  word_val = BUF_SIZE;
      W_RADDR:  word_val = BUF_ADDR;
      default:  word_val = 32'd0;
    endcase
  end
  assign bus_rdata = word_val >> {bus_addr[1:0], 3'b000};

  assert_start_from_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> start_bit && !$past(start_bit));
  assert_cancel_inflight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_pulse |-> $past(start_bit));
  assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !start_bit && !start_req);
  assert_err_fatal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && done_err) |=> fatal);
  assert_req_other_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_req && wword != 32'd1 && wword != 32'd2) |=> $stable(idle));
  assert_grant_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    granted == loc_assigned);
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> !start_req);
endmodule

// File: tb/crb_ctrl_regs_tb_top.sv
module crb_ctrl_regs_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_size = 2'd3;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        est_flag = 1'b1, done_strb = 1'b0, done_err = 1'b0;
  logic        start_req, cancel_pulse;
  int n_tests = 0, n_fail = 0;

  crb_ctrl_regs dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .est_flag(est_flag),
    .done_strb(done_strb), .done_err(done_err), .start_req(start_req),
    .cancel_pulse(cancel_pulse));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic rd(string req, logic [15:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  // drive at negedge, returns at the following negedge (outputs of that edge visible)
  task automatic wr(logic [15:0] a, logic [1:0] sz, logic [31:0] d);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_size = 2'd3;
  endtask

  task automatic done(logic err);
    done_strb = 1'b1; done_err = err;
    @(negedge clk);
    done_strb = 1'b0; done_err = 1'b0;
  endtask

  task automatic t_reset;
    rd("R1 loc_state", 16'h0000, 32'h80);
    rd("R1 loc_sts", 16'h000C, 32'h0);
    rd("R1 ctrl_sts", 16'h0044, 32'h2);
    rd("R1 start", 16'h004C, 32'h0);
    rd("R1 intf_id", 16'h0030, 32'h0002_5811);
    rd("R1 intf_id2", 16'h0034, 32'h1014);
    rd("R1 cmd_size", 16'h0058, 32'hF80);
    rd("R1 cmd_addr", 16'h005C, 32'hFED4_0080);
    rd("R1 rsp_size", 16'h0064, 32'hF80);
    rd("R1 rsp_addr", 16'h0068, 32'hFED4_0080);
    check("R1 start_req", {31'd0, start_req}, 32'd0);
  endtask

  task automatic t_est;
    est_flag = 1'b0;
    rd("R2 est low", 16'h0000, 32'h81);
    rd("R2 est low window 2", 16'h2000, 32'h81);
    est_flag = 1'b1;
    rd("R2 est high", 16'h0000, 32'h80);
  endtask

  task automatic t_subword;
    rd("R3 off1", 16'h0031, 32'h0000_0258);
    rd("R3 off2", 16'h0032, 32'h0000_0002);
    rd("R3 off3", 16'h005F, 32'h0000_00FE);
  endtask

  task automatic t_ctrl_req;
    wr(16'h0040, 2'd3, 32'h3); rd("R4 both bits ignored", 16'h0044, 32'h2);
    wr(16'h0040, 2'd3, 32'h1); rd("R4 cmd ready", 16'h0044, 32'h0);
    wr(16'h0040, 2'd3, 32'h3); rd("R4 both bits ignored ready", 16'h0044, 32'h0);
    wr(16'h0040, 2'd3, 32'h2); rd("R4 go idle", 16'h0044, 32'h2);
  endtask

  task automatic t_locality;
    wr(16'h0008, 2'd3, 32'h8); rd("R5 reset-est no effect", 16'h0000, 32'h80);
    wr(16'h0008, 2'd3, 32'h1); rd("R5 request", 16'h0000, 32'h82);
    rd("R5 granted", 16'h000C, 32'h1);
    wr(16'h0008, 2'd3, 32'h3); rd("R5 other ignored", 16'h0000, 32'h82);
    wr(16'h0008, 2'd3, 32'h2); rd("R5 relinquish", 16'h0000, 32'h80);
    rd("R5 relinquish sts", 16'h000C, 32'h0);
  endtask

  task automatic t_start_reject;
    wr(16'h004C, 2'd3, 32'h1);
    check("R7 unassigned no pulse", {31'd0, start_req}, 32'd0);
    rd("R7 unassigned start", 16'h004C, 32'h0);
    wr(16'h0008, 2'd3, 32'h1);
    wr(16'h104C, 2'd3, 32'h1);
    check("R7 wrong locality no pulse", {31'd0, start_req}, 32'd0);
    rd("R7 wrong locality start", 16'h004C, 32'h0);
    wr(16'h004C, 2'd3, 32'h3);
    check("R7 wrong value no pulse", {31'd0, start_req}, 32'd0);
    wr(16'h004D, 2'd0, 32'h1);
    check("R10 lane1 byte ignored", {31'd0, start_req}, 32'd0);
    rd("R10 lane1 start", 16'h004C, 32'h0);
    wr(16'h0048, 2'd3, 32'h1);
    check("R8 cancel idle no pulse", {31'd0, cancel_pulse}, 32'd0);
    done(1'b1);
    rd("R9 stray done ignored", 16'h0044, 32'h2);
  endtask

  task automatic t_start_run;
    wr(16'h004C, 2'd0, 32'h0000_0101);
    check("R6 R10 accept pulse", {31'd0, start_req}, 32'd1);
    @(negedge clk);
    check("R6 pulse one cycle", {31'd0, start_req}, 32'd0);
    rd("R6 start bit", 16'h004C, 32'h1);
    wr(16'h004C, 2'd3, 32'h1);
    check("R7 already set no pulse", {31'd0, start_req}, 32'd0);
    wr(16'h0048, 2'd3, 32'h1);
    check("R8 cancel pulse", {31'd0, cancel_pulse}, 32'd1);
    @(negedge clk);
    check("R8 cancel one cycle", {31'd0, cancel_pulse}, 32'd0);
    done(1'b0);
    rd("R9 done clears start", 16'h004C, 32'h0);
    rd("R9 no fatal", 16'h0044, 32'h2);
    wr(16'h004C, 2'd3, 32'h1);
    check("R6 restart pulse", {31'd0, start_req}, 32'd1);
    done(1'b1);
    rd("R9 err sets fatal", 16'h0044, 32'h3);
    rd("R9 err clears start", 16'h004C, 32'h0);
    wr(16'h0040, 2'd3, 32'h1);
    rd("R9 fatal sticky", 16'h0044, 32'h1);
  endtask

  task automatic t_readonly;
    wr(16'h0030, 2'd3, 32'hFFFF_FFFF); rd("R11 intf_id", 16'h0030, 32'h0002_5811);
    wr(16'h0000, 2'd3, 32'hFFFF_FFFF); rd("R11 loc_state", 16'h0000, 32'h82);
    wr(16'h0044, 2'd3, 32'h0);         rd("R11 ctrl_sts", 16'h0044, 32'h1);
    wr(16'h0058, 2'd3, 32'h0);         rd("R11 cmd_size", 16'h0058, 32'hF80);
    wr(16'h0200, 2'd3, 32'hFFFF_FFFF); rd("R11 unmapped", 16'h0200, 32'h0);
    rd("R11 start unchanged", 16'h004C, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_est();
    t_subword();
    t_ctrl_req();
    t_locality();
    t_start_reject();
    t_start_run();
    t_readonly();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule